// File: doc/BRIEF.md
# Dual-Output Compare-Match PWM Timer

This block is a single timer channel that produces two pulse-width-modulated outputs from one 16-bit up-counter and one clock prescaler. Software programs it through a small word-wide register port: a control word (prescaler code and counter-clear source), a run bit, a per-output drive-enable word and four 16-bit compare registers named A, B, C and D. Output 0 uses A as its period and B as its duty point. Output 1 uses C as its period and D as its duty point.

The counter restarts at zero whenever it matches the compare register that the clear-source bit selects. Each output goes high when the count restarts and falls when the count reaches its duty value. The prescaler divides the clock by a power of four and is shared, so both outputs always advance at the same rate. A two-state run controller has two states. ST_STOP holds the counter and prescaler at zero, and START moves it to ST_RUN when the run bit is set. ST_RUN counts, and HALT returns it to ST_STOP when the run bit is cleared. An output that is disabled, or whose channel is stopped, deasserts its output enable so that the pad floats.

Top module: `pwm_dual_timer`

## Requirements
- R1: After reset every register reads zero, the controller is in ST_STOP, and both `pwm_oe` bits and both `pwm_out` bits are 0.
- R2: Register map by `addr`: 0 control (bits 1:0 prescaler code, bit 2 clear source), 1 run (bit 0), 2 drive enable (bit 0 output 0, bit 1 output 1), 3 A, 4 B, 5 C, 6 D. Every register reads back what was written, and unused bits read zero.
- R3: A prescaler code k makes the counter advance once every 4^k clocks. The counter counts 0..P and then clears, so one period lasts (P+1)·4^k clocks.
- R4: When clear source is 0 the counter clears on a match with A. When it is 1 the counter clears on a match with C.
- R5: Each output is high at the start of every period for duty·4^k clocks and low for the rest of the period. Output 0 uses B as its duty and A as its period. Output 1 uses D as its duty and C as its period.
- R6: When the duty value is greater than or equal to the output's period register, the output stays high. When the duty value is 0 and the period register is not zero, the output stays low.
- R7: While the run bit is set, writes to the control register are ignored, and the read-back value and the counting rate do not change.
- R8: Setting the run bit takes the controller from ST_STOP to ST_RUN on the following edge, with the counter and prescaler starting from zero. `pwm_oe` rises after the second rising edge that follows the write. Clearing the run bit drops `pwm_oe` after the second rising edge that follows that write.
- R9: `pwm_oe[i]` is 1 only when the controller is in ST_RUN and drive-enable bit i is set. When `pwm_oe[i]` is 0, `pwm_out[i]` is 0.
- R10: A compare-register write takes effect on the outputs right after the edge that stores it, even while the counter is running.
- R11: Both outputs run at the same time from the shared counter, each with its own duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pwm_out | output | 2 | PWM levels, bit i is output i |
| pwm_oe | output | 2 | Output enables. 0 means the pad floats |

## Verification
A write is stored on the edge where `wr_en` is sampled. Compare and enable changes show on the outputs right after that edge. A run-bit change reaches `pwm_oe` one edge later, because the controller registers it. The bench drives inputs on falling edges and samples there, so it checks `pwm_oe` low one falling edge after a start write and high on the next one. High and low times are counted over two whole periods, starting on the first falling edge with the output enabled. That first sample is count zero of the first prescaler interval, so the expected counts are exactly duty·4^k per period and (P+1)·4^k per period.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] RG_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] RG_RUN  = 3'd1;
    localparam logic [ADDR_W-1:0] RG_DRV  = 3'd2;
    localparam logic [ADDR_W-1:0] RG_CA   = 3'd3;
    localparam logic [ADDR_W-1:0] RG_CB   = 3'd4;
    localparam logic [ADDR_W-1:0] RG_CC   = 3'd5;
    localparam logic [ADDR_W-1:0] RG_CD   = 3'd6;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [PSC_W-1:0] code,
    output logic             tick
);
    localparam int PRE_W = 2 * ((1 << PSC_W) - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = (PRE_W'(1) << {code, 1'b0}) - PRE_W'(1);
        tick  = running && (pre_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!running || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/pwm_run_ctrl.sv
module pwm_run_ctrl
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic             tick,
    input  logic [CNT_W-1:0] clr_val,
    output logic             running,
    output logic [CNT_W-1:0] cnt
);
    run_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (run_req)  state_d = ST_RUN;
            ST_RUN:  if (!run_req) state_d = ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_STOP: cnt_q <= '0;
                ST_RUN: begin
                    if (tick) begin
                        cnt_q <= (cnt_q == clr_val) ? '0 : cnt_q + CNT_W'(1);
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        running = (state_q == ST_RUN);
        cnt     = cnt_q;
    end
endmodule

// File: rtl/pwm_out_unit.sv
module pwm_out_unit #(
    parameter int CNT_W = 16
) (
    input  logic             running,
    input  logic             drive_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             lvl,
    output logic             oe
);
    logic level;

    always_comb begin
        if (duty >= period) begin
            level = 1'b1;
        end else begin
            level = (cnt < duty);
        end
        oe  = running && drive_en;
        lvl = oe && level;
    end
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 2,
    parameter int N_OUT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [N_OUT-1:0]  pwm_out,
    output logic [N_OUT-1:0]  pwm_oe
);
    localparam int CTRL_W = PSC_W + 1;
    localparam int N_CMP  = 2 * N_OUT;

    logic [CTRL_W-1:0] ctrl_q;
    logic              run_q;
    logic [N_OUT-1:0]  drv_q;
    logic [CNT_W-1:0]  cmp_q [N_CMP];

    logic              running;
    logic              tick;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  clr_val;
    logic [PSC_W-1:0]  psc_code;
    logic              clr_sel;

    always_comb begin
        psc_code = ctrl_q[PSC_W-1:0];
        clr_sel  = ctrl_q[PSC_W];
        clr_val  = clr_sel ? cmp_q[2] : cmp_q[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            run_q  <= 1'b0;
            drv_q  <= '0;
            for (int i = 0; i < N_CMP; i++) cmp_q[i] <= '0;
        end else if (wr_en) begin
            unique case (addr)
                RG_CTRL: if (!run_q) ctrl_q <= wdata[CTRL_W-1:0];
                RG_RUN:  run_q <= wdata[0];
                RG_DRV:  drv_q <= wdata[N_OUT-1:0];
                RG_CA:   cmp_q[0] <= wdata;
                RG_CB:   cmp_q[1] <= wdata;
                RG_CC:   cmp_q[2] <= wdata;
                RG_CD:   cmp_q[3] <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RG_CTRL: rdata = CNT_W'(ctrl_q);
            RG_RUN:  rdata = CNT_W'(run_q);
            RG_DRV:  rdata = CNT_W'(drv_q);
            RG_CA:   rdata = cmp_q[0];
            RG_CB:   rdata = cmp_q[1];
            RG_CC:   rdata = cmp_q[2];
            RG_CD:   rdata = cmp_q[3];
            default: rdata = '0;
        endcase
    end

    pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .code    (psc_code),
        .tick    (tick)
    );

    pwm_run_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_req (run_q),
        .tick    (tick),
        .clr_val (clr_val),
        .running (running),
        .cnt     (cnt)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        pwm_out_unit #(.CNT_W(CNT_W)) u_out (
            .running  (running),
            .drive_en (drv_q[g]),
            .cnt      (cnt),
            .period   (cmp_q[2*g]),
            .duty     (cmp_q[2*g+1]),
            .lvl      (pwm_out[g]),
            .oe       (pwm_oe[g])
        );
    end
endmodule

// File: rtl/pwm_dual_timer_chk.sv
module pwm_dual_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int CTRL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_q,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              running,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  per0,
    input logic [CNT_W-1:0]  duty0,
    input logic [1:0]        drv_q,
    input logic [1:0]        pwm_out,
    input logic [1:0]        pwm_oe
);
    a_r9_low_when_floating0: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_oe[0] |-> !pwm_out[0]);

    a_r9_low_when_floating1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_oe[1] |-> !pwm_out[1]);

    a_r7_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> $stable(ctrl_q));

    a_r8_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (cnt == '0));

    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> $stable(cnt));

    a_r6_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (running && drv_q[0] && duty0 == '0 && per0 != '0) |-> !pwm_out[0]);
endmodule

bind pwm_dual_timer pwm_dual_timer_chk #(.CNT_W(16), .CTRL_W(3)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_q   (run_q),
    .ctrl_q  (ctrl_q),
    .running (running),
    .tick    (tick),
    .cnt     (cnt),
    .per0    (cmp_q[0]),
    .duty0   (cmp_q[1]),
    .drv_q   (drv_q),
    .pwm_out (pwm_out),
    .pwm_oe  (pwm_oe)
);

// File: tb/pwm_dual_timer_test.sv
module pwm_dual_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  pwm_out;
    logic [1:0]  pwm_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pwm_dual_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        addr = a;
        #1 d = int'(rdata);
    endtask

    task automatic start_run();
        wr(3'd1, 16'd1);
        @(negedge clk);
    endtask

    task automatic stop_run();
        wr(3'd1, 16'd0);
        @(negedge clk);
    endtask

    // Samples w falling edges beginning at the current one.
    task automatic measure(input int w, output int h0, output int h1,
                           output int f0, output int f1);
        bit lo0 = 0, lo1 = 0;
        h0 = 0; h1 = 0; f0 = 0; f1 = 0;
        for (int i = 0; i < w; i++) begin
            if (pwm_out[0]) begin h0++; if (!lo0) f0++; end else lo0 = 1;
            if (pwm_out[1]) begin h1++; if (!lo1) f1++; end else lo1 = 1;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int d;
        chk("R1 oe", int'(pwm_oe), 0);
        chk("R1 out", int'(pwm_out), 0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk("R1 reg", d, 0);
        end
    endtask

    task automatic t_map();
        int d;
        wr(3'd0, 16'hFFFF); rd(3'd0, d); chk("R2 ctrl", d, 7);
        wr(3'd2, 16'hFFFF); rd(3'd2, d); chk("R2 drv", d, 3);
        wr(3'd3, 16'h1234); rd(3'd3, d); chk("R2 A", d, 16'h1234);
        wr(3'd4, 16'hABCD); rd(3'd4, d); chk("R2 B", d, 16'hABCD);
        wr(3'd5, 16'h0F0F); rd(3'd5, d); chk("R2 C", d, 16'h0F0F);
        wr(3'd6, 16'h8001); rd(3'd6, d); chk("R2 D", d, 16'h8001);
        rd(3'd7, d); chk("R2 unused", d, 0);
    endtask

    task automatic t_prescale();
        int h0, h1, f0, f1, dv;
        wr(3'd3, 16'd9); wr(3'd4, 16'd3); wr(3'd2, 16'd1);
        for (int k = 0; k < 4; k++) begin
            dv = 1 << (2 * k);
            wr(3'd0, 16'(k));
            start_run();
            measure(2 * 10 * dv, h0, h1, f0, f1);
            chk($sformatf("R3 high total k=%0d", k), h0, 2 * 3 * dv);
            chk($sformatf("R5 first high k=%0d", k), f0, 3 * dv);
            stop_run();
        end
    endtask

    task automatic t_start_timing();
        wr(3'd0, 16'd0); wr(3'd3, 16'd9); wr(3'd4, 16'd3); wr(3'd2, 16'd1);
        wr(3'd1, 16'd1);
        chk("R8 oe low after one edge", int'(pwm_oe[0]), 0);
        @(negedge clk);
        chk("R8 oe high after two edges", int'(pwm_oe[0]), 1);
        wr(3'd1, 16'd0);
        chk("R8 oe still high one edge after stop", int'(pwm_oe[0]), 1);
        @(negedge clk);
        chk("R8 oe low two edges after stop", int'(pwm_oe[0]), 0);
        chk("R9 out low when stopped", int'(pwm_out[0]), 0);
    endtask

    task automatic t_dual();
        int h0, h1, f0, f1;
        wr(3'd0, 16'd1); wr(3'd3, 16'd9); wr(3'd4, 16'd3);
        wr(3'd5, 16'd9); wr(3'd6, 16'd7); wr(3'd2, 16'd3);
        start_run();
        measure(2 * 10 * 4, h0, h1, f0, f1);
        chk("R11 out0 high", h0, 2 * 3 * 4);
        chk("R11 out1 high", h1, 2 * 7 * 4);
        chk("R11 out1 first high", f1, 7 * 4);
        stop_run();
    endtask

    task automatic t_clr_c();
        int h0, h1, f0, f1;
        wr(3'd0, 16'd4); wr(3'd3, 16'd100); wr(3'd4, 16'd2);
        wr(3'd5, 16'd7); wr(3'd6, 16'd5); wr(3'd2, 16'd3);
        start_run();
        measure(2 * 8, h0, h1, f0, f1);
        chk("R4 clear on C out1", h1, 2 * 5);
        chk("R4 clear on C out0", h0, 2 * 2);
        stop_run();
    endtask

    task automatic t_extremes();
        int h0, h1, f0, f1;
        wr(3'd0, 16'd0); wr(3'd3, 16'd9); wr(3'd4, 16'd12);
        wr(3'd5, 16'd9); wr(3'd6, 16'd0); wr(3'd2, 16'd3);
        start_run();
        measure(30, h0, h1, f0, f1);
        chk("R6 duty above period high", h0, 30);
        chk("R6 zero duty low", h1, 0);
        stop_run();
    endtask

    task automatic t_ctrl_locked();
        int d, h0, h1, f0, f1;
        wr(3'd0, 16'd0); wr(3'd3, 16'd9); wr(3'd4, 16'd3); wr(3'd2, 16'd1);
        start_run();
        wr(3'd0, 16'd7);
        rd(3'd0, d);
        chk("R7 ctrl readback", d, 0);
        stop_run();
        start_run();
        measure(20, h0, h1, f0, f1);
        chk("R7 rate unchanged", h0, 6);
        stop_run();
    endtask

    task automatic t_drive_and_live();
        int h0, h1, f0, f1;
        wr(3'd0, 16'd0); wr(3'd3, 16'd9); wr(3'd4, 16'd3);
        wr(3'd5, 16'd9); wr(3'd6, 16'd9); wr(3'd2, 16'd3);
        start_run();
        wr(3'd2, 16'd1);
        chk("R9 oe1 dropped", int'(pwm_oe[1]), 0);
        chk("R9 out1 low", int'(pwm_out[1]), 0);
        chk("R9 oe0 kept", int'(pwm_oe[0]), 1);
        wr(3'd4, 16'd0);
        chk("R10 duty zero immediate", int'(pwm_out[0]), 0);
        measure(20, h0, h1, f0, f1);
        chk("R10 stays low", h0, 0);
        wr(3'd4, 16'd9);
        measure(20, h0, h1, f0, f1);
        chk("R10 duty=period high", h0, 20);
        stop_run();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_start_timing();
        t_prescale();
        t_dual();
        t_clr_c();
        t_extremes();
        t_ctrl_locked();
        t_drive_and_live();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule